// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core that switches between privileged operating modes. The datapath addresses sixteen architectural registers with a 4-bit number. A 3-bit mode input selects which physical register each number reaches. Numbers 0 to 7 and the program counter (number 15) are the same in every mode. The fast-interrupt mode has its own copies of numbers 8 to 14. The four other exception modes (normal interrupt, supervisor, abort, undefined) each have their own copies of numbers 13 and 14 only, the stack pointer and link register. The privileged system mode sees exactly the user registers. In total it holds thirty general-purpose physical registers and the program counter.

Each exception mode also has a saved status register. A separate write path and read path reach it, and the current mode selects which one. The program counter has its own next-value input and write enable, so the fetch stage can advance it while the register write port is busy. Decode, the ALU and flag generation are outside the block.

All ports are plain, level-sampled control and data signals. There is no valid/ready handshake and no back-pressure: a read is answered in the same cycle, and a write is taken on every rising edge where its enable is high. Forwarding a value written in the same cycle is left to the datapath.

Top module: `banked_regfile`

## Requirements
- R1: While the active-low reset rst_n is low, every physical register, the program counter and every saved status register is cleared to zero. After release, reads in any mode return 0.
- R2: Register numbers 0 to 7 and number 15 reach the same storage in every mode. Number 15 reads the program counter, which is also driven on pc_out.
- R3: In mode code 1 (fast interrupt), numbers 8 to 14 reach a private bank. Writes there leave the user copies untouched, and the reverse also holds.
- R4: Mode codes 2 (interrupt), 3 (supervisor), 4 (abort) and 5 (undefined) each have private copies of numbers 13 and 14. In these modes, numbers 8 to 12 reach the user copies.
- R5: Mode code 6 (system) and the unused code 7 reach exactly the registers of mode code 0 (user).
- R6: A write is stored on the rising edge where wr_en is high and shows on the read ports from the next cycle on. A read of the same register in the write cycle returns the old value.
- R7: When pc_we is high, the program counter loads pc_next on the edge. A write-port write to number 15 also loads the program counter and wins over pc_we in the same cycle. With neither enable high, the program counter holds its value.
- R8: Mode codes 1 to 5 each own one saved status register. spsr_we writes, and spsr_rdata reads, the register of the current mode. A write shows on the read path from the next cycle on.
- R9: In mode codes 0, 6 and 7, spsr_rdata reads 0 and spsr_we has no effect on any saved status register.
- R10: The two read ports are independent. Both may address the same register in the same cycle and both return its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Current mode code (0 user, 1 fast irq, 2 irq, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 as user) |
| rd_a_idx | input | 4 | Architectural number for read port A |
| rd_a_data | output | 32 | Read port A data, same cycle |
| rd_b_idx | input | 4 | Architectural number for read port B |
| rd_b_data | output | 32 | Read port B data, same cycle |
| wr_en | input | 1 | Write enable for the register write port |
| wr_idx | input | 4 | Architectural number for the write |
| wr_data | input | 32 | Write data |
| pc_we | input | 1 | Program counter update enable |
| pc_next | input | 32 | Next program counter value |
| pc_out | output | 32 | Current program counter |
| spsr_we | input | 1 | Saved status write enable for the current mode |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status of the current mode, 0 in user/system |

## Verification
Read data, pc_out and spsr_rdata are combinational and due in the same cycle as the index and mode that select them. Register, program counter and saved status writes are due one rising edge later. The driver applies each stimulus on the falling edge and queues the values due in that cycle. The monitor checks them 1 ns before the next rising edge, so every result is sampled before the edge that could change it. A check that needs the effect of a write is queued in the cycle after the one that carries the write. Same-cycle checks in a write cycle therefore capture the old value that R6 calls for.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5,
    MD_SYS = 3'd6,
    MD_RSV = 3'd7
  } mode_e;

  localparam int ARCH_W      = 4;
  localparam int PC_NUM      = 15;
  localparam int SHARED_TOP  = 8;   // numbers below this are never banked
  localparam int FAST_TOP    = 13;  // fast-irq bank covers SHARED_TOP..FAST_TOP-1 too
  localparam int FAST_CNT    = FAST_TOP - SHARED_TOP;
  localparam int SPLR_CNT    = 2;   // stack pointer and link register
  localparam int SPLR_BANKS  = 6;   // user, fiq, irq, svc, abt, und
  localparam int FAST_BASE   = FAST_TOP;               // private fast copies of 8..12
  localparam int SPLR_BASE   = FAST_BASE + FAST_CNT;   // first stack-pointer copy
  localparam int PHYS_REGS   = SPLR_BASE + SPLR_CNT * SPLR_BANKS;
  localparam int PHYS_W      = $clog2(PHYS_REGS);
  localparam int NUM_SAVED   = 5;
  localparam int SAVED_W     = $clog2(NUM_SAVED);

  // bank used for the stack pointer / link register pair
  function automatic int splr_bank(mode_e m);
    case (m)
      MD_FIQ:  return 1;
      MD_IRQ:  return 2;
      MD_SVC:  return 3;
      MD_ABT:  return 4;
      MD_UND:  return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic has_saved(mode_e m);
    return (m inside {MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND});
  endfunction

endpackage

// File: rtl/brf_index_map.sv
module brf_index_map
  import banked_rf_pkg::*;
(
  input  mode_e                   mode,
  input  logic [ARCH_W-1:0]       idx,
  output logic [PHYS_W-1:0]       phys,
  output logic                    is_pc
);

  int num;
  int bank;

  always_comb begin
    num   = int'(idx);
    bank  = splr_bank(mode);
    is_pc = (num == PC_NUM);
    if (num == PC_NUM) begin
      phys = '0;
    end else if (num < SHARED_TOP) begin
      phys = PHYS_W'(num);
    end else if (num < FAST_TOP) begin
      phys = (mode == MD_FIQ) ? PHYS_W'(num - SHARED_TOP + FAST_BASE) : PHYS_W'(num);
    end else begin
      phys = PHYS_W'(SPLR_BASE + SPLR_CNT * bank + (num - FAST_TOP));
    end
  end

endmodule

// File: rtl/brf_gpr_array.sv
module brf_gpr_array
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PHYS_W-1:0]   ra_phys,
  input  logic                ra_pc,
  output logic [DATA_W-1:0]   ra_data,
  input  logic [PHYS_W-1:0]   rb_phys,
  input  logic                rb_pc,
  output logic [DATA_W-1:0]   rb_data,
  input  logic                wr_en,
  input  logic [PHYS_W-1:0]   wr_phys,
  input  logic                wr_pc,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pc_we,
  input  logic [DATA_W-1:0]   pc_next,
  output logic [DATA_W-1:0]   pc_q
);

  logic [DATA_W-1:0] regs_q [PHYS_REGS];

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && !wr_pc && (int'(wr_phys) == g))
        regs_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (wr_en && wr_pc)
      pc_q <= wr_data;
    else if (pc_we)
      pc_q <= pc_next;
  end

  function automatic logic [DATA_W-1:0] pick(logic [PHYS_W-1:0] p, logic pc_sel,
                                             logic [DATA_W-1:0] pcv);
    if (pc_sel)                   return pcv;
    else if (int'(p) < PHYS_REGS) return regs_q[p];
    else                          return '0;
  endfunction

  assign ra_data = pick(ra_phys, ra_pc, pc_q);
  assign rb_data = pick(rb_phys, rb_pc, pc_q);

  assert_wr_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_pc && int'(wr_phys) < PHYS_REGS) |=> (regs_q[$past(wr_phys)] == $past(wr_data)))
    else $error("written value not stored");

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !(wr_en && wr_pc)) |=> $stable(pc_q))
    else $error("pc changed without enable");

  assert_pc_port_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pc) |=> (pc_q == $past(wr_data)))
    else $error("write port did not win pc update");

endmodule

// File: rtl/brf_saved_bank.sv
module brf_saved_bank
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mode_e               mode,
  input  logic                we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic [NUM_SAVED-1:0][DATA_W-1:0] saved_q;
  logic                             valid_mode;
  logic [SAVED_W-1:0]               slot;

  always_comb begin
    valid_mode = has_saved(mode);
    slot       = valid_mode ? SAVED_W'(int'(mode) - 1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SAVED; i++)
        if (we && valid_mode && (int'(slot) == i))
          saved_q[i] <= wdata;
    end
  end

  assign rdata = valid_mode ? saved_q[slot] : '0;

  assert_saved_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_mode) |=> $stable(saved_q))
    else $error("saved status changed from unbanked mode");

  assert_saved_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && valid_mode) |=> (saved_q[$past(slot)] == $past(wdata)))
    else $error("saved status write lost");

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic [ARCH_W-1:0]   rd_a_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [ARCH_W-1:0]   rd_b_idx,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                wr_en,
  input  logic [ARCH_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pc_we,
  input  logic [DATA_W-1:0]   pc_next,
  output logic [DATA_W-1:0]   pc_out,
  input  logic                spsr_we,
  input  logic [DATA_W-1:0]   spsr_wdata,
  output logic [DATA_W-1:0]   spsr_rdata
);

  localparam int NPORTS = 3;  // read A, read B, write

  mode_e             cur_mode;
  logic [ARCH_W-1:0] port_idx  [NPORTS];
  logic [PHYS_W-1:0] port_phys [NPORTS];
  logic              port_pc   [NPORTS];

  assign cur_mode    = mode_e'(mode);
  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_map
    brf_index_map u_map (
      .mode (cur_mode),
      .idx  (port_idx[p]),
      .phys (port_phys[p]),
      .is_pc(port_pc[p])
    );
  end

  brf_gpr_array #(.DATA_W(DATA_W)) u_gpr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_phys(port_phys[0]),
    .ra_pc  (port_pc[0]),
    .ra_data(rd_a_data),
    .rb_phys(port_phys[1]),
    .rb_pc  (port_pc[1]),
    .rb_data(rd_b_data),
    .wr_en  (wr_en),
    .wr_phys(port_phys[2]),
    .wr_pc  (port_pc[2]),
    .wr_data(wr_data),
    .pc_we  (pc_we),
    .pc_next(pc_next),
    .pc_q   (pc_out)
  );

  brf_saved_bank #(.DATA_W(DATA_W)) u_saved (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (cur_mode),
    .we   (spsr_we),
    .wdata(spsr_wdata),
    .rdata(spsr_rdata)
  );

  assert_same_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data))
    else $error("read ports disagree on one register");

  assert_shared_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_a_idx) < SHARED_TOP) |-> (int'(port_phys[0]) == int'(rd_a_idx)))
    else $error("low register remapped");

endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/100ps
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_out, spsr_rdata;
  logic        wr_en = 1'b0, pc_we = 1'b0, spsr_we = 1'b0;
  logic [31:0] wr_data = '0, pc_next = '0, spsr_wdata = '0;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_we(pc_we), .pc_next(pc_next), .pc_out(pc_out),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata)
  );

  typedef struct {
    int          sel;   // 0 read A, 1 read B, 2 pc_out, 3 spsr_rdata
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] UBASE = 32'h1000_0000;

  // driver: every cycle is fully described
  task automatic step(input int md, input int ra, input int rb,
                      input bit we = 0, input int wi = 0, input logic [31:0] wd = '0,
                      input bit pwe = 0, input logic [31:0] pn = '0,
                      input bit swe = 0, input logic [31:0] swd = '0);
    @(negedge clk);
    mode = 3'(md); rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    pc_we = pwe; pc_next = pn;
    spsr_we = swe; spsr_wdata = swd;
  endtask

  task automatic expect_v(input int sel, input logic [31:0] v, input string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: sample 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = rd_a_data;
          1:       act = rd_b_data;
          2:       act = pc_out;
          default: act = spsr_rdata;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    step(0, 0, 15);
    expect_v(0, 32'h0, "R1 r0 user");
    expect_v(1, 32'h0, "R1 r15 user");
    expect_v(2, 32'h0, "R1 pc_out");
    step(3, 13, 14);
    expect_v(0, 32'h0, "R1 svc r13");
    expect_v(3, 32'h0, "R1 svc saved status");

    // fill user r0..r14
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, i, UBASE + 32'(i));

    step(1, 5, 8);
    expect_v(0, UBASE + 5, "R2 fiq sees user r5");
    expect_v(1, 32'h0,     "R3 fiq r8 private");
    step(1, 14, 7);
    expect_v(0, 32'h0,     "R3 fiq r14 private");
    expect_v(1, UBASE + 7, "R2 fiq sees user r7");
    step(2, 8, 13);
    expect_v(0, UBASE + 8, "R4 irq r8 shared");
    expect_v(1, 32'h0,     "R4 irq r13 private");
    step(6, 13, 12);
    expect_v(0, UBASE + 13, "R5 system r13 is user");
    expect_v(1, UBASE + 12, "R5 system r12 is user");
    step(7, 14, 9);
    expect_v(0, UBASE + 14, "R5 code 7 r14 is user");
    expect_v(1, UBASE + 9,  "R5 code 7 r9 is user");

    // R3 fast-irq private writes
    step(1, 0, 0, 1, 8, 32'hAAAA_0008);
    step(1, 0, 0, 1, 14, 32'hAAAA_000E);
    step(1, 8, 14);
    expect_v(0, 32'hAAAA_0008, "R3 fiq r8 written");
    expect_v(1, 32'hAAAA_000E, "R3 fiq r14 written");
    step(0, 8, 14);
    expect_v(0, UBASE + 8,  "R3 user r8 untouched");
    expect_v(1, UBASE + 14, "R3 user r14 untouched");

    // R4 per-mode stack pointers
    step(2, 0, 0, 1, 13, 32'hC0C0_0002);
    step(3, 0, 0, 1, 13, 32'hC0C0_0003);
    step(2, 13, 8);
    expect_v(0, 32'hC0C0_0002, "R4 irq r13");
    expect_v(1, UBASE + 8,     "R4 irq r8 user copy");
    step(3, 13, 14);
    expect_v(0, 32'hC0C0_0003, "R4 svc r13");
    expect_v(1, 32'h0,         "R4 svc r14 private");
    step(4, 13, 13);
    expect_v(0, 32'h0, "R4 abort r13 private");
    step(5, 14, 13);
    expect_v(0, 32'h0, "R4 undef r14 private");
    expect_v(1, 32'h0, "R4 undef r13 private");

    // R5 system write lands in user bank
    step(6, 0, 0, 1, 13, 32'h5555_000D);
    step(0, 13, 13);
    expect_v(0, 32'h5555_000D, "R5 user sees system write");

    // R6 same-cycle read returns old value
    step(0, 3, 3, 1, 3, 32'hF00D_0003);
    expect_v(0, UBASE + 3, "R6 same-cycle old value");
    step(0, 3, 2);
    expect_v(0, 32'hF00D_0003, "R6 next-cycle new value");
    expect_v(1, UBASE + 2,     "R6 neighbour unchanged");

    // R7 program counter
    step(0, 0, 0, 0, 0, '0, 1, 32'h0000_0100);
    step(1, 15, 0);
    expect_v(2, 32'h0000_0100, "R7 pc loaded");
    expect_v(0, 32'h0000_0100, "R2 r15 in fiq is pc");
    step(0, 0, 0, 1, 15, 32'h0000_0200, 1, 32'h0000_0300);
    step(0, 15, 15);
    expect_v(2, 32'h0000_0200, "R7 write port wins");
    step(0, 0, 0);
    expect_v(2, 32'h0000_0200, "R7 pc holds");

    // R8 saved status per mode
    for (int m = 1; m <= 5; m++) step(m, 0, 0, 0, 0, '0, 0, '0, 1, 32'h5A00_0000 + 32'(m));
    for (int m = 1; m <= 5; m++) begin
      step(m, 0, 0);
      expect_v(3, 32'h5A00_0000 + 32'(m), "R8 saved status per mode");
    end

    // R9 unbanked modes
    step(0, 0, 0, 0, 0, '0, 0, '0, 1, 32'hDEAD_0000);
    expect_v(3, 32'h0, "R9 user reads zero");
    step(6, 0, 0, 0, 0, '0, 0, '0, 1, 32'hDEAD_0006);
    expect_v(3, 32'h0, "R9 system reads zero");
    step(7, 0, 0, 0, 0, '0, 0, '0, 1, 32'hDEAD_0007);
    expect_v(3, 32'h0, "R9 code 7 reads zero");
    for (int m = 1; m <= 5; m++) begin
      step(m, 0, 0);
      expect_v(3, 32'h5A00_0000 + 32'(m), "R9 banks untouched");
    end

    // R10 independent read ports
    step(1, 8, 8);
    expect_v(0, 32'hAAAA_0008, "R10 port A same index");
    expect_v(1, 32'hAAAA_0008, "R10 port B same index");
    step(3, 13, 6);
    expect_v(0, 32'hC0C0_0003, "R10 port A");
    expect_v(1, UBASE + 6,     "R10 port B");

    step(0, 0, 0);
    step(0, 0, 0);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule